// File: doc/BRIEF.md
# Bit-Manipulation ALU

A purely combinational execution unit for a 32- or 64-bit integer datapath. It covers the common bit-manipulation operations: leading and trailing zero counts, population count, logic operations with an inverted second operand, signed and unsigned minimum and maximum, narrow sign and zero extension, rotates by a register or an immediate amount, byte reversal, and a per-byte "any bit set" combine. Instruction decode and pipeline control stay outside the block. The surrounding pipeline presents an operation code, two operands, an immediate rotate amount, a word-mode flag and an enable, and it takes the result in the same cycle.

The word-mode flag selects the 32-bit forms that a 64-bit core uses. These forms work on the low 32 bits of the operands only. Each of them fills the upper half of the result in its own way. Counts come back zero-extended and word rotates come back sign-extended from bit 31. The `accepted` output tells the pipeline whether the requested operation exists for this configuration. When `accepted` is low, the result is forced to zero.

Top module: `bmu_alu`

## Requirements
- R1: Operation codes on `op_sel` are 0 clz, 1 ctz, 2 cpop, 3 andn, 4 orn, 5 xnor, 6 min, 7 max, 8 minu, 9 maxu, 10 sext.b, 11 sext.h, 12 zext.h, 13 rol, 14 ror, 15 rori, 16 rev8, 17 orc.b. Codes 18 to 31 are illegal. `accepted` is 1 only when `ext_en` is 1 and the code is legal (see R12 for word mode). When `accepted` is 0, `result` is all zero.
- R2: clz returns the number of zero bits above the highest set bit of `src_a`, and returns XLEN when `src_a` is zero. In word mode it counts within bits 31:0 only and returns 32 when those bits are zero.
- R3: ctz returns the number of zero bits below the lowest set bit, and returns XLEN for a zero operand. In word mode it returns 32 when bits 31:0 are zero, whatever the upper bits hold.
- R4: cpop returns the number of set bits of `src_a`. In word mode it counts bits 31:0 only.
- R5: andn gives a & ~b, orn gives a | ~b, and xnor gives ~(a ^ b).
- R6: min and max compare the operands as two's-complement numbers. minu and maxu compare them as unsigned numbers. The result is always one of the two operands.
- R7: sext.b copies bit 7 into all higher bits, sext.h copies bit 15 into all higher bits, and zext.h clears bits XLEN-1:16.
- R8: rol and ror rotate `src_a` by the low log2(XLEN) bits of `src_b`. rori rotates right by `shamt_imm`. Higher bits of `src_b` are ignored.
- R9: Word rotates rotate bits 31:0 of `src_a` within 32 bits, by amount bits 4:0. Every result bit above bit 31 equals result bit 31.
- R10: rev8 reverses the byte order of the whole operand. Byte k of the result is byte XLEN/8-1-k of `src_a`.
- R11: orc.b writes 0xFF to each result byte whose source byte is nonzero and 0x00 to each result byte whose source byte is zero.
- R12: Word mode is accepted only when XLEN is 64 and the operation is clz, ctz, cpop, rol, ror or rori. Any other combination gives `accepted` 0 and a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (see R1) |
| word_mode | input | 1 | Select the 32-bit word form |
| ext_en | input | 1 | Bit-manipulation support enabled |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand / rotate amount |
| shamt_imm | input | log2(XLEN) | Immediate rotate amount |
| result | output | XLEN | Operation result |
| accepted | output | 1 | Operation legal and performed |

## Verification
The block holds no state, so any fault in a count, rotate or byte path appears on `result` in the same cycle as the operands that expose it. The bench pairs each vector with a reference model result. The corner vectors are the ones where a count loop's boundary, a word-mode truncation or a wrapped rotate amount takes effect. Examples are a zero low word with a nonzero upper half, a rotate by zero, and an amount with stray high bits. A wrongly decoded legality flag shows at once as a missing zero fill or a wrong `accepted`. This matters most for word-mode operations that have no word form.

// File: rtl/bmu_pkg.sv
`timescale 1ns/1ps
package bmu_pkg;
   typedef enum logic [4:0] {
      OP_CLZ   = 5'd0,
      OP_CTZ   = 5'd1,
      OP_CPOP  = 5'd2,
      OP_ANDN  = 5'd3,
      OP_ORN   = 5'd4,
      OP_XNOR  = 5'd5,
      OP_MIN   = 5'd6,
      OP_MAX   = 5'd7,
      OP_MINU  = 5'd8,
      OP_MAXU  = 5'd9,
      OP_SEXTB = 5'd10,
      OP_SEXTH = 5'd11,
      OP_ZEXTH = 5'd12,
      OP_ROL   = 5'd13,
      OP_ROR   = 5'd14,
      OP_RORI  = 5'd15,
      OP_REV8  = 5'd16,
      OP_ORCB  = 5'd17
   } bmu_op_e;

   localparam logic [4:0] OP_LAST = 5'd17;

   function automatic logic has_word_form(logic [4:0] op);
      return op inside {OP_CLZ, OP_CTZ, OP_CPOP, OP_ROL, OP_ROR, OP_RORI};
   endfunction
endpackage

// File: rtl/bmu_cnt.sv
`timescale 1ns/1ps
module bmu_cnt #(
   parameter int XLEN = 64,
   parameter int CW   = 7
) (
   input  logic [XLEN-1:0] src,
   input  logic            word,
   output logic [CW-1:0]   lz,
   output logic [CW-1:0]   tz,
   output logic [CW-1:0]   pop
);
   localparam int WW = 32;

   always_comb begin
      int  n_lz;
      int  n_tz;
      int  n_pop;
      int  top;
      logic hit_hi;
      logic hit_lo;
      top    = word ? WW : XLEN;
      n_lz   = 0;
      n_tz   = 0;
      n_pop  = 0;
      hit_hi = 1'b0;
      hit_lo = 1'b0;
      for (int i = XLEN - 1; i >= 0; i--) begin
         if (i < top) begin
            if (src[i]) hit_hi = 1'b1;
            else if (!hit_hi) n_lz++;
         end
      end
      for (int i = 0; i < XLEN; i++) begin
         if (i < top) begin
            if (src[i]) begin
               hit_lo = 1'b1;
               n_pop++;
            end else if (!hit_lo) begin
               n_tz++;
            end
         end
      end
      lz  = CW'(n_lz);
      tz  = CW'(n_tz);
      pop = CW'(n_pop);
   end
endmodule

// File: rtl/bmu_rot.sv
`timescale 1ns/1ps
module bmu_rot #(
   parameter int XLEN = 64,
   parameter int SHW  = 6
) (
   input  logic [XLEN-1:0] data,
   input  logic [SHW-1:0]  amt,
   input  logic            left,
   input  logic            word,
   output logic [XLEN-1:0] res
);
   logic [SHW-1:0]    s_full;
   logic [4:0]        s_word;
   logic [2*XLEN-1:0] dbl_full;
   logic [63:0]       dbl_word;
   logic signed [31:0] r32;

   // A left rotate by s is a right rotate by (width - s) mod width.
   assign s_full   = left ? SHW'(0 - amt) : amt;
   assign s_word   = left ? 5'(0 - amt[4:0]) : amt[4:0];
   assign dbl_full = {data, data} >> s_full;
   assign dbl_word = {data[31:0], data[31:0]} >> s_word;
   assign r32      = dbl_word[31:0];

   assign res = word ? XLEN'(r32) : dbl_full[XLEN-1:0];
endmodule

// File: rtl/bmu_bytes.sv
`timescale 1ns/1ps
module bmu_bytes #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] src,
   output logic [XLEN-1:0] rev,
   output logic [XLEN-1:0] orc
);
   localparam int NB = XLEN / 8;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rev[8*b +: 8] = src[8*(NB-1-b) +: 8];
      assign orc[8*b +: 8] = {8{|src[8*b +: 8]}};
   end
endmodule

// File: rtl/bmu_alu.sv
`timescale 1ns/1ps
module bmu_alu
   import bmu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [4:0]              op_sel,
   input  logic                    word_mode,
   input  logic                    ext_en,
   input  logic [XLEN-1:0]         src_a,
   input  logic [XLEN-1:0]         src_b,
   input  logic [$clog2(XLEN)-1:0] shamt_imm,
   output logic [XLEN-1:0]         result,
   output logic                    accepted
);
   localparam int SHW = $clog2(XLEN);
   localparam int CW  = $clog2(XLEN + 1);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("bmu_alu: XLEN must be 32 or 64");
   end

   logic [CW-1:0]   n_lz, n_tz, n_pop;
   logic [XLEN-1:0] rot_out, rev_out, orc_out;
   logic [XLEN-1:0] raw;
   logic [SHW-1:0]  rot_amt;
   logic            rot_left;
   logic            op_legal, word_legal;
   logic            a_lt_b_s, a_lt_b_u;

   bmu_cnt #(.XLEN(XLEN), .CW(CW)) u_cnt (
      .src  (src_a),
      .word (word_mode),
      .lz   (n_lz),
      .tz   (n_tz),
      .pop  (n_pop)
   );

   assign rot_amt  = (op_sel == OP_RORI) ? shamt_imm : src_b[SHW-1:0];
   assign rot_left = (op_sel == OP_ROL);

   bmu_rot #(.XLEN(XLEN), .SHW(SHW)) u_rot (
      .data (src_a),
      .amt  (rot_amt),
      .left (rot_left),
      .word (word_mode),
      .res  (rot_out)
   );

   bmu_bytes #(.XLEN(XLEN)) u_bytes (
      .src (src_a),
      .rev (rev_out),
      .orc (orc_out)
   );

   assign a_lt_b_s = $signed(src_a) < $signed(src_b);
   assign a_lt_b_u = src_a < src_b;

   always_comb begin
      case (op_sel)
         OP_CLZ:   raw = XLEN'(n_lz);
         OP_CTZ:   raw = XLEN'(n_tz);
         OP_CPOP:  raw = XLEN'(n_pop);
         OP_ANDN:  raw = src_a & ~src_b;
         OP_ORN:   raw = src_a | ~src_b;
         OP_XNOR:  raw = ~(src_a ^ src_b);
         OP_MIN:   raw = a_lt_b_s ? src_a : src_b;
         OP_MAX:   raw = a_lt_b_s ? src_b : src_a;
         OP_MINU:  raw = a_lt_b_u ? src_a : src_b;
         OP_MAXU:  raw = a_lt_b_u ? src_b : src_a;
         OP_SEXTB: raw = XLEN'($signed(src_a[7:0]));
         OP_SEXTH: raw = XLEN'($signed(src_a[15:0]));
         OP_ZEXTH: raw = XLEN'(src_a[15:0]);
         OP_ROL, OP_ROR, OP_RORI: raw = rot_out;
         OP_REV8:  raw = rev_out;
         OP_ORCB:  raw = orc_out;
         default:  raw = '0;
      endcase
   end

   assign op_legal   = (op_sel <= OP_LAST);
   assign word_legal = (XLEN == 64) && has_word_form(op_sel);
   assign accepted   = ext_en && op_legal && (!word_mode || word_legal);
   assign result     = accepted ? raw : '0;
endmodule

// File: rtl/bmu_alu_chk.sv
`timescale 1ns/1ps
module bmu_alu_chk
   import bmu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input logic [4:0]              op_sel,
   input logic                    word_mode,
   input logic                    ext_en,
   input logic [XLEN-1:0]         src_a,
   input logic [XLEN-1:0]         src_b,
   input logic [$clog2(XLEN)-1:0] shamt_imm,
   input logic [XLEN-1:0]         result,
   input logic                    accepted
);
   localparam logic [XLEN-1:0] ONES = '1;

   always_comb begin
      if (!$isunknown({op_sel, word_mode, ext_en, src_a, src_b, shamt_imm, result, accepted})) begin
         // R1
         gate_off_chk: assert (ext_en || (!accepted && result == '0));
         // R1
         zero_fill_chk: assert (accepted || result == '0);
         // R12
         word_form_chk: assert (!(accepted && word_mode) || (XLEN == 64 && has_word_form(op_sel)));
         // R2
         clz_range_chk: assert (!(accepted && op_sel == OP_CLZ) ||
                                result <= (word_mode ? XLEN'(32) : XLEN'(XLEN)));
         // R4
         pop_range_chk: assert (!(accepted && op_sel == OP_CPOP && word_mode) || result <= XLEN'(32));
         // R6
         minmax_pick_chk: assert (!(accepted && op_sel inside {OP_MIN, OP_MAX, OP_MINU, OP_MAXU}) ||
                                  result == src_a || result == src_b);
         // R9
         wrot_ext_chk: assert (!(accepted && word_mode && op_sel inside {OP_ROL, OP_ROR, OP_RORI}) ||
                               (result >> 31) == '0 || (result >> 31) == (ONES >> 31));
         for (int b = 0; b < XLEN / 8; b++) begin
            // R11
            orcb_byte_chk: assert (!(accepted && op_sel == OP_ORCB) ||
                                   result[8*b +: 8] == 8'h00 || result[8*b +: 8] == 8'hFF);
         end
      end
   end
endmodule

bind bmu_alu bmu_alu_chk #(.XLEN(XLEN)) u_bmu_alu_chk (
   .op_sel    (op_sel),
   .word_mode (word_mode),
   .ext_en    (ext_en),
   .src_a     (src_a),
   .src_b     (src_b),
   .shamt_imm (shamt_imm),
   .result    (result),
   .accepted  (accepted)
);

// File: tb/tb_bmu_alu.sv
`timescale 1ns/1ps
module tb_bmu_alu;
   logic        clk = 1'b0;
   logic [4:0]  op_sel = '0;
   logic        word_mode = 1'b0;
   logic        ext_en = 1'b0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [5:0]  shamt_imm = '0;
   logic [63:0] result;
   logic        accepted;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   bmu_alu #(.XLEN(64)) dut (
      .op_sel    (op_sel),
      .word_mode (word_mode),
      .ext_en    (ext_en),
      .src_a     (src_a),
      .src_b     (src_b),
      .shamt_imm (shamt_imm),
      .result    (result),
      .accepted  (accepted)
   );

   function automatic string req_of(int op, bit w, bit en);
      if (!en || op > 17) return "R1";
      if (w && !(op inside {0, 1, 2, 13, 14, 15})) return "R12";
      if (w && op >= 13) return "R9";
      case (op)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3, 4, 5: return "R5";
         6, 7, 8, 9: return "R6";
         10, 11, 12: return "R7";
         13, 14, 15: return "R8";
         16: return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [63:0] model(int op, bit w, bit en, logic [63:0] a,
                                         logic [63:0] b, logic [5:0] imm, output bit acc);
      int n;
      int cnt;
      int s;
      logic [63:0] r;
      bit stop;
      acc = en && op <= 17 && (!w || op inside {0, 1, 2, 13, 14, 15});
      if (!acc) return 64'd0;
      n = w ? 32 : 64;
      r = '0;
      cnt = 0;
      stop = 1'b0;
      case (op)
         0: begin
            for (int i = n - 1; i >= 0; i--) begin
               if (a[i]) stop = 1'b1;
               if (!stop) cnt++;
            end
            r = 64'(cnt);
         end
         1: begin
            for (int i = 0; i < n; i++) begin
               if (a[i]) stop = 1'b1;
               if (!stop) cnt++;
            end
            r = 64'(cnt);
         end
         2: begin
            for (int i = 0; i < n; i++) cnt += int'(a[i]);
            r = 64'(cnt);
         end
         3: r = a & ~b;
         4: r = a | ~b;
         5: r = ~(a ^ b);
         6: r = ($signed(a) < $signed(b)) ? a : b;
         7: r = ($signed(a) > $signed(b)) ? a : b;
         8: r = (a < b) ? a : b;
         9: r = (a > b) ? a : b;
         10: begin r = {64{a[7]}};  r[7:0]  = a[7:0];  end
         11: begin r = {64{a[15]}}; r[15:0] = a[15:0]; end
         12: r = {48'd0, a[15:0]};
         16: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
         17: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
         default: begin
            s = (op == 15) ? int'(imm) : int'(b[5:0]);
            s = s % n;
            for (int i = 0; i < n; i++) begin
               if (op == 13) r[(i + s) % n] = a[i];
               else          r[i] = a[(i + s) % n];
            end
            if (w) r[63:32] = {32{r[31]}};
         end
      endcase
      return r;
   endfunction

   task automatic apply(int op, bit w, bit en, logic [63:0] a, logic [63:0] b, logic [5:0] imm);
      logic [63:0] exp_r;
      bit exp_a;
      @(posedge clk);
      op_sel = 5'(op);
      word_mode = w;
      ext_en = en;
      src_a = a;
      src_b = b;
      shamt_imm = imm;
      exp_r = model(op, w, en, a, b, imm, exp_a);
      @(negedge clk);
      n_checks++;
      if (result !== exp_r || accepted !== exp_a) begin
         n_fail++;
         $display("FAIL %s op=%0d w=%0d en=%0d: got acc=%0b res=%h, expected acc=%0b res=%h",
                  req_of(op, w, en), op, w, en, accepted, result, exp_a, exp_r);
      end
   endtask

   function automatic logic [63:0] pick_operand();
      case ($urandom_range(0, 7))
         0: return 64'd0;
         1: return '1;
         2: return {32'($urandom), 32'd0};
         3: return 64'($urandom_range(0, 255)) << (8 * $urandom_range(0, 7));
         4: return 64'h1 << $urandom_range(0, 63);
         default: return {32'($urandom), 32'($urandom)};
      endcase
   endfunction

   initial begin
      void'($urandom(32'd1234));
      // Reset-like idle state: disabled unit gives nothing (R1)
      @(negedge clk);
      n_checks++;
      if (accepted !== 1'b0 || result !== 64'd0) begin
         n_fail++;
         $display("FAIL R1 idle: got acc=%0b res=%h, expected acc=0 res=0", accepted, result);
      end
      // R2 / R3 zero operand, full and word
      apply(0, 0, 1, 64'd0, 64'd0, 6'd0);
      apply(0, 1, 1, 64'hFFFF_0000_0000_0000, 64'd0, 6'd0);
      apply(0, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 6'd0);
      apply(1, 0, 1, 64'd0, 64'd0, 6'd0);
      apply(1, 1, 1, 64'h0000_0001_0000_0000, 64'd0, 6'd0);
      apply(1, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 6'd0);
      // R4 word counts low half only
      apply(2, 1, 1, 64'hFFFF_FFFF_0000_00F0, 64'd0, 6'd0);
      apply(2, 0, 1, '1, 64'd0, 6'd0);
      // R6 sign boundaries
      apply(6, 0, 1, 64'h8000_0000_0000_0000, 64'd1, 6'd0);
      apply(8, 0, 1, 64'h8000_0000_0000_0000, 64'd1, 6'd0);
      apply(7, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd0);
      // R7 extension sign bits
      apply(10, 0, 1, 64'h1234_5678_9ABC_DE80, 64'd0, 6'd0);
      apply(11, 0, 1, 64'h1234_5678_9ABC_7FFF, 64'd0, 6'd0);
      apply(12, 0, 1, 64'hFFFF_FFFF_FFFF_8001, 64'd0, 6'd0);
      // R8 rotate by zero and stray high amount bits
      apply(14, 0, 1, 64'h0123_4567_89AB_CDEF, 64'd0, 6'd0);
      apply(13, 0, 1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF44, 6'd0);
      apply(15, 0, 1, 64'h0123_4567_89AB_CDEF, '1, 6'd63);
      // R9 word rotates, result bit 31 set and clear
      apply(14, 1, 1, 64'hDEAD_BEEF_0000_0001, 64'd1, 6'd0);
      apply(13, 1, 1, 64'h0000_0000_8000_0000, 64'd33, 6'd0);
      apply(15, 1, 1, 64'hFFFF_FFFF_1234_5678, 64'd0, 6'd36);
      // R10 / R11
      apply(16, 0, 1, 64'h0102_0304_0506_0708, 64'd0, 6'd0);
      apply(17, 0, 1, 64'h0080_0001_0000_FF00, 64'd0, 6'd0);
      // R12 word mode on operations without a word form
      apply(16, 1, 1, 64'h0102_0304_0506_0708, 64'd0, 6'd0);
      apply(3, 1, 1, '1, 64'd0, 6'd0);
      // R1 illegal code and disabled
      apply(18, 0, 1, '1, '1, 6'd5);
      apply(5, 0, 0, 64'd3, 64'd5, 6'd0);
      // Constrained random
      for (int i = 0; i < 4000; i++) begin
         apply(int'($urandom_range(0, 19)), ($urandom_range(0, 3) == 0),
               ($urandom_range(0, 7) != 0), pick_operand(), pick_operand(), 6'($urandom));
      end
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule